// File: doc/BRIEF.md
# Magnetometer ADC Command Translator

This block lets a host start a complete magnetometer conversion with one command. The host picks a read type with a two-bit pseudo command. The block expands it into the SPI frames that the ADC needs. The ADC never starts a conversion on its own, so every read begins with a host command. The block shifts each returned sample into a host-readable result register. It reports progress with a busy flag and a done flag, and it sets sticky error and overrun flags for commands it refuses.

A field-vector read runs three SPI frames, for X, then Y, then Z, on either the inboard or the outboard sensor. A temperature read runs one frame and returns the outboard thermistor value. Each frame keeps chip select low for 24 SCLK periods. The first 8 bits are a command byte sent MSB first. During the next 16 bits the ADC returns its sample, also MSB first.

Command handshake rules: `cmd_ready` equals the inverse of `busy`. A command is taken when `cmd_valid` is high on a clock edge. If `cmd_ready` is low at that edge, the command is not queued and never stalls. It is dropped and recorded as an overrun. The host is expected to wait for `cmd_ready` before it issues a command. At the default SCLK divider a vector read takes about 600 clock cycles. That is far below the interval between reads when the host polls at 64 Hz.

Top module: `magcmd_xlator`

## Requirements
- R1: After reset, busy, done, err_bad_cmd and overrun are 0, all result registers are 0, spi_cs_n is 1 and spi_sclk is 0.
- R2: Code 2'b00 (inboard vector) runs exactly three frames with command bytes 0x80, 0x88 and 0x90. The returned samples are stored in res_x, res_y and res_z, in that order.
- R3: Code 2'b01 (outboard vector) runs exactly three frames with command bytes 0xA0, 0xA8 and 0xB0. The samples are stored in res_x, res_y and res_z. The command byte layout is {2'b10, outboard bit, channel[1:0] (X=0, Y=1, Z=2, temp=3), 3'b000}.
- R4: Code 2'b10 (outboard temperature) runs exactly one frame with command byte 0xB8 and stores the sample in res_temp. res_x, res_y and res_z keep their values.
- R5: Code 2'b11 is rejected. No SPI frame runs, err_bad_cmd is set, busy stays 0 and done is cleared. The next accepted command clears err_bad_cmd.
- R6: busy rises in the cycle after a command is accepted. It falls in the same cycle that the last result register is written, and done rises in that cycle. busy and done are never both 1. Result registers do not change while the block is idle.
- R7: A command presented while busy is ignored: it starts no frames and changes no results. It sets overrun, and the next accepted command clears overrun.
- R8: The SPI link uses mode 0. SCLK is low whenever chip select is high. Each frame has 24 SCLK rising edges. MOSI is MSB first and is sampled on the rising edge, and MISO is sampled on the rising edge. Chip select goes high between frames.
- R9: done stays 1 until the next command is presented while idle, and that command clears it in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Pseudo command present |
| cmd_code | input | 2 | Pseudo command code |
| cmd_ready | output | 1 | Block can accept a command (not busy) |
| busy | output | 1 | Conversion sequence in progress |
| done | output | 1 | Results of the last command valid |
| err_bad_cmd | output | 1 | Sticky flag: last command was code 2'b11 |
| overrun | output | 1 | Sticky flag: a command arrived while busy |
| res_x | output | DATA_W | X-axis sample |
| res_y | output | DATA_W | Y-axis sample |
| res_z | output | DATA_W | Z-axis sample |
| res_temp | output | DATA_W | Thermistor sample |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Command bits to ADC |
| spi_miso | input | 1 | Sample bits from ADC |

## Verification
The bench sweeps all four pseudo-command codes, each with three different ADC response patterns. An SPI slave model in the bench returns a sample built from the command byte it received plus a per-run pattern byte. A misrouted axis, a wrong sensor bit, or a temperature sample stored in a vector register each produces a different wrong value. The sequence that sends a second command while busy shows whether the overrun command leaked into the frames or the results. A bad code shows whether any frame starts at all.

// File: rtl/magcmd_pkg.sv
package magcmd_pkg;
  typedef enum logic [1:0] {
    PC_IN_VEC  = 2'b00,
    PC_OUT_VEC = 2'b01,
    PC_OUT_TMP = 2'b10,
    PC_BAD     = 2'b11
  } pcmd_e;

  typedef enum logic [1:0] {
    CH_X = 2'd0,
    CH_Y = 2'd1,
    CH_Z = 2'd2,
    CH_T = 2'd3
  } chan_e;

  localparam int          CMD_BITS = 8;
  localparam logic [1:0]  OPC_CONV = 2'b10;

  // ADC command byte: opcode, sensor select, channel, padding
  function automatic logic [CMD_BITS-1:0] adc_cmd(input logic outboard, input chan_e ch);
    return {OPC_CONV, outboard, ch, 3'b000};
  endfunction
endpackage

// File: rtl/magcmd_decode.sv
module magcmd_decode
  import magcmd_pkg::*;
(
  input  logic [1:0] code,
  output logic       ok,
  output logic       outboard,
  output chan_e      first_ch,
  output chan_e      last_ch
);
  always_comb begin
    ok       = 1'b1;
    outboard = 1'b0;
    first_ch = CH_X;
    last_ch  = CH_Z;
    unique case (pcmd_e'(code))
      PC_IN_VEC:  outboard = 1'b0;
      PC_OUT_VEC: outboard = 1'b1;
      PC_OUT_TMP: begin
        outboard = 1'b1;
        first_ch = CH_T;
        last_ch  = CH_T;
      end
      PC_BAD:     ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/magcmd_spi.sv
module magcmd_spi #(
  parameter int HALF      = 4,
  parameter int CMD_BITS  = 8,
  parameter int DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CMD_BITS-1:0]  tx_byte,
  output logic                 frame_done,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 sclk,
  output logic                 cs_n,
  output logic                 mosi,
  input  logic                 miso
);
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS;
  localparam int DW         = $clog2(HALF + 1);
  localparam int BW         = $clog2(FRAME_BITS + 1);
  localparam logic [DW-1:0] DIV_END = DW'(HALF - 1);
  localparam logic [BW-1:0] BIT_END = BW'(FRAME_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_e;

  st_e                 st;
  logic [DW-1:0]       div;
  logic [BW-1:0]       bitn;
  logic                phase;
  logic [CMD_BITS-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      div        <= '0;
      bitn       <= '0;
      phase      <= 1'b0;
      tx         <= '0;
      rx_data    <= '0;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st    <= S_SHIFT;
          cs_n  <= 1'b0;
          div   <= '0;
          bitn  <= '0;
          phase <= 1'b0;
          tx    <= tx_byte;
        end
        S_SHIFT: begin
          if (div == DIV_END) begin
            div <= '0;
            if (!phase) begin
              phase   <= 1'b1;
              sclk    <= 1'b1;
              rx_data <= {rx_data[DATA_BITS-2:0], miso};
            end else begin
              phase <= 1'b0;
              sclk  <= 1'b0;
              tx    <= {tx[CMD_BITS-2:0], 1'b0};
              if (bitn == BIT_END) begin
                st   <= S_GAP;
                cs_n <= 1'b1;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        S_GAP: begin
          if (div == DIV_END) begin
            div        <= '0;
            st         <= S_IDLE;
            frame_done <= 1'b1;
          end else begin
            div <= div + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mosi = (st == S_SHIFT) ? tx[CMD_BITS-1] : 1'b0;
endmodule

// File: rtl/magcmd_seq.sv
module magcmd_seq
  import magcmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic                dec_ok,
  input  logic                dec_outboard,
  input  chan_e               dec_first,
  input  chan_e               dec_last,
  output logic                frame_start,
  output logic [CMD_BITS-1:0] frame_byte,
  input  logic                frame_done,
  input  logic [DATA_W-1:0]   frame_data,
  output logic                busy,
  output logic                done,
  output logic                err_bad,
  output logic                ovr,
  output logic [DATA_W-1:0]   res_x,
  output logic [DATA_W-1:0]   res_y,
  output logic [DATA_W-1:0]   res_z,
  output logic [DATA_W-1:0]   res_t
);
  logic  outb;
  chan_e ch, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      err_bad     <= 1'b0;
      ovr         <= 1'b0;
      outb        <= 1'b0;
      ch          <= CH_X;
      last        <= CH_X;
      frame_start <= 1'b0;
      res_x       <= '0;
      res_y       <= '0;
      res_z       <= '0;
      res_t       <= '0;
    end else begin
      frame_start <= 1'b0;
      if (cmd_valid) begin
        if (busy) begin
          ovr <= 1'b1;
        end else if (!dec_ok) begin
          err_bad <= 1'b1;
          done    <= 1'b0;
        end else begin
          busy        <= 1'b1;
          done        <= 1'b0;
          err_bad     <= 1'b0;
          ovr         <= 1'b0;
          outb        <= dec_outboard;
          ch          <= dec_first;
          last        <= dec_last;
          frame_start <= 1'b1;
        end
      end
      if (busy && frame_done) begin
        unique case (ch)
          CH_X: res_x <= frame_data;
          CH_Y: res_y <= frame_data;
          CH_Z: res_z <= frame_data;
          CH_T: res_t <= frame_data;
        endcase
        if (ch == last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ch          <= chan_e'(ch + 2'd1);
          frame_start <= 1'b1;
        end
      end
    end
  end

  assign frame_byte = adc_cmd(outb, ch);
endmodule

// File: rtl/magcmd_xlator.sv
module magcmd_xlator
  import magcmd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SCLK_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic              err_bad_cmd,
  output logic              overrun,
  output logic [DATA_W-1:0] res_x,
  output logic [DATA_W-1:0] res_y,
  output logic [DATA_W-1:0] res_z,
  output logic [DATA_W-1:0] res_temp,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic                dec_ok, dec_outb;
  chan_e               dec_first, dec_last;
  logic                f_start, f_done;
  logic [CMD_BITS-1:0] f_byte;
  logic [DATA_W-1:0]   f_data;

  magcmd_decode u_dec (
    .code     (cmd_code),
    .ok       (dec_ok),
    .outboard (dec_outb),
    .first_ch (dec_first),
    .last_ch  (dec_last)
  );

  magcmd_seq #(.DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .dec_ok       (dec_ok),
    .dec_outboard (dec_outb),
    .dec_first    (dec_first),
    .dec_last     (dec_last),
    .frame_start  (f_start),
    .frame_byte   (f_byte),
    .frame_done   (f_done),
    .frame_data   (f_data),
    .busy         (busy),
    .done         (done),
    .err_bad      (err_bad_cmd),
    .ovr          (overrun),
    .res_x        (res_x),
    .res_y        (res_y),
    .res_z        (res_z),
    .res_t        (res_temp)
  );

  magcmd_spi #(.HALF(SCLK_HALF), .CMD_BITS(CMD_BITS), .DATA_BITS(DATA_W)) u_spi (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (f_start),
    .tx_byte    (f_byte),
    .frame_done (f_done),
    .rx_data    (f_data),
    .sclk       (spi_sclk),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi),
    .miso       (spi_miso)
  );

  assign cmd_ready = ~busy;
endmodule

// File: rtl/magcmd_xlator_chk.sv
module magcmd_xlator_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_code,
  input logic              busy,
  input logic              done,
  input logic              err_bad_cmd,
  input logic              overrun,
  input logic [DATA_W-1:0] res_x,
  input logic [DATA_W-1:0] res_temp,
  input logic              spi_sclk,
  input logic              spi_cs_n
);
  // R8
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6
  busy_end_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (spi_cs_n && done));

  // R6
  idle_res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$rose(done) && !$fell(busy)) |-> ($stable(res_x) && $stable(res_temp)));

  // R5
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_code == 2'b11) |=> (err_bad_cmd && !busy && !done));

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> overrun);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> !done);
endmodule

bind magcmd_xlator magcmd_xlator_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .busy        (busy),
  .done        (done),
  .err_bad_cmd (err_bad_cmd),
  .overrun     (overrun),
  .res_x       (res_x),
  .res_temp    (res_temp),
  .spi_sclk    (spi_sclk),
  .spi_cs_n    (spi_cs_n)
);

// File: tb/magcmd_xlator_test.sv
`timescale 1ns/1ps
module magcmd_xlator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_code = 2'b00;
  logic        cmd_ready, busy, done, err_bad_cmd, overrun;
  logic [15:0] res_x, res_y, res_z, res_temp;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // slave model state
  logic [7:0] pat = 8'h00;
  int         nframes = 0;
  logic [7:0] fbyte [0:7];
  int         frises [0:7];

  // expected result model
  logic [15:0] ex_x = 0, ex_y = 0, ex_z = 0, ex_t = 0;

  always #2.5 clk = ~clk;

  magcmd_xlator uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .busy(busy), .done(done), .err_bad_cmd(err_bad_cmd),
    .overrun(overrun), .res_x(res_x), .res_y(res_y), .res_z(res_z),
    .res_temp(res_temp), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input bit outb, input int ch);
    return 8'h80 | (8'(outb) << 5) | (8'(ch) << 3);
  endfunction

  // mode-0 SPI slave: records command byte, returns {command byte, pattern}
  initial begin
    forever begin
      int rc;
      logic [7:0]  cb;
      logic [15:0] resp;
      @(negedge spi_cs_n);
      rc = 0; cb = 0; resp = 0;
      while (1) begin
        @(posedge spi_sclk or posedge spi_cs_n);
        if (spi_cs_n) break;
        rc++;
        if (rc <= 8) cb = {cb[6:0], spi_mosi};
        if (rc == 8) resp = {cb, pat};
        @(negedge spi_sclk or posedge spi_cs_n);
        if (spi_cs_n) break;
        if (rc >= 8 && rc < 24) spi_miso = resp[23-rc];
      end
      spi_miso = 1'b0;
      if (nframes < 8) begin
        fbyte[nframes]  = cb;
        frises[nframes] = rc;
      end
      nframes++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_code(input logic [1:0] c, input logic [7:0] p);
    int nexp;
    bit outb;
    int ch0;
    pat = p;
    nframes = 0;
    issue(c);
    if (c == 2'b11) begin
      chk(err_bad_cmd == 1'b1, "R5 err set", int'(err_bad_cmd), 1);
      chk(busy == 1'b0, "R5 busy stays low", int'(busy), 0);
      chk(done == 1'b0, "R5 done cleared", int'(done), 0);
      repeat (300) @(negedge clk);
      chk(nframes == 0, "R5 no frames", nframes, 0);
      chk({res_x, res_y, res_z, res_temp} == {ex_x, ex_y, ex_z, ex_t},
          "R5 results unchanged", int'(res_x), int'(ex_x));
      return;
    end
    chk(busy == 1'b1 && cmd_ready == 1'b0, "R6 busy after accept", int'(busy), 1);
    chk(done == 1'b0, "R9 done cleared on command", int'(done), 0);
    chk(err_bad_cmd == 1'b0, "R5 err cleared by good command", int'(err_bad_cmd), 0);
    wait_idle();
    chk(done == 1'b1 && busy == 1'b0, "R6 done at end", int'(done), 1);
    outb = (c != 2'b00);
    nexp = (c == 2'b10) ? 1 : 3;
    ch0  = (c == 2'b10) ? 3 : 0;
    chk(nframes == nexp, (c == 2'b10) ? "R4 frame count" : "R2 frame count", nframes, nexp);
    for (int i = 0; i < nexp && i < 8; i++) begin
      logic [7:0] eb;
      eb = exp_byte(outb, ch0 + i);
      chk(fbyte[i] == eb, (c == 2'b00) ? "R2 cmd byte" : (c == 2'b01) ? "R3 cmd byte" : "R4 cmd byte",
          int'(fbyte[i]), int'(eb));
      chk(frises[i] == 24, "R8 rising edges per frame", frises[i], 24);
      unique case (ch0 + i)
        0: ex_x = {eb, p};
        1: ex_y = {eb, p};
        2: ex_z = {eb, p};
        default: ex_t = {eb, p};
      endcase
    end
    chk(res_x == ex_x, (c == 2'b10) ? "R4 res_x kept" : "R2 R3 res_x", int'(res_x), int'(ex_x));
    chk(res_y == ex_y, (c == 2'b10) ? "R4 res_y kept" : "R2 R3 res_y", int'(res_y), int'(ex_y));
    chk(res_z == ex_z, (c == 2'b10) ? "R4 res_z kept" : "R2 R3 res_z", int'(res_z), int'(ex_z));
    chk(res_temp == ex_t, "R4 res_temp", int'(res_temp), int'(ex_t));
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R9 done holds while idle", int'(done), 1);
  endtask

  initial begin
    logic [7:0] pats [0:2];
    pats[0] = 8'h5A; pats[1] = 8'hC3; pats[2] = 8'h0F;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({busy, done, err_bad_cmd, overrun} == 4'b0000, "R1 flags", int'({busy, done, err_bad_cmd, overrun}), 0);
    chk({res_x, res_y, res_z, res_temp} == 64'd0, "R1 results", int'(res_x), 0);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 spi idle", int'({spi_cs_n, spi_sclk}), 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 4; c++)
        run_code(2'(c), pats[s]);

    // R7 overrun: second command while busy is dropped
    pat = 8'h99;
    nframes = 0;
    issue(2'b00);
    repeat (40) @(negedge clk);
    issue(2'b10);
    chk(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
    wait_idle();
    chk(nframes == 3, "R7 no extra frames", nframes, 3);
    ex_x = {8'h80, 8'h99}; ex_y = {8'h88, 8'h99}; ex_z = {8'h90, 8'h99};
    chk(res_x == ex_x && res_y == ex_y && res_z == ex_z, "R7 results of first command",
        int'(res_z), int'(ex_z));
    chk(res_temp == ex_t, "R7 temp untouched", int'(res_temp), int'(ex_t));
    chk(overrun == 1'b1, "R7 overrun sticky", int'(overrun), 1);
    issue(2'b01);
    chk(overrun == 1'b0, "R7 overrun cleared by accept", int'(overrun), 0);
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule